// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block looks at every interrupt line seen by one CPU interface and picks the single line that should be signalled to that CPU. For each line it receives the enable bit, the pending latch, the active bit, the live input level, a trigger-mode bit (edge or level), a group bit, an 8-bit priority and an 8-bit mask of target CPUs. It also takes four inputs that belong to the CPU: its priority mask, its running priority, and two 2-bit group enable fields. One comes from the shared distributor and one from the CPU interface.

A line is eligible when it is enabled, effectively pending, not active and aimed at this CPU. The eligible line with the numerically smallest priority wins. A balanced comparator tree settles the winner in one cycle. The result is then gated by the CPU's priority mask, its running priority and the group enables, and is registered. The selected ID, its priority and the interrupt request all change one clock after the inputs that caused them. When nothing qualifies, the block reports ID 1023 and priority 0x100.

Top module: `prio_select`

## Requirements
- R1: While reset is held, and after it, until the first update, `sel_id` reads 1023, `sel_prio` reads 0x100 and `irq_req` is 0.
- R2: A line takes part in selection only when its enable is 1, it is effectively pending and its active bit is 0. A line with active set, or with enable clear, is never selected.
- R3: Among eligible lines the smallest priority value wins. When two lines have the same priority, the one with the lower ID wins.
- R4: A line counts as pending when its pending latch is 1. It also counts as pending when its level input is 1 and its trigger-mode bit is 0, where 0 means level and 1 means edge. With the trigger-mode bit at 1, a high level alone does not make the line pending.
- R5: Lines with IDs 0 to 31 are private to the CPU and skip the target check. A line with ID 32 or above is eligible only if bit `CPU_IDX` of its 8-bit target field (`line_tgt[id*8 +: 8]`) is 1.
- R6: When the best priority is strictly below `prio_mask`, `sel_id` and `sel_prio` show the winner. Otherwise they show 1023 and 0x100, and `irq_req` is 0.
- R7: `irq_req` is 1 only when the best priority is also strictly below the 9-bit `run_prio`, where 0x100 means idle. A shown winner with an insufficient priority leaves `irq_req` at 0.
- R8: For a winner in group g (its group bit: 0 is group 0, 1 is group 1), `irq_req` also needs bit g of `dist_grp_en` and bit g of `cpu_grp_en` to both be 1.
- R9: All three outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released through an internal synchronizer |
| line_en | input | NUM_LINES | Per-line enable |
| line_pend | input | NUM_LINES | Per-line pending latch |
| line_act | input | NUM_LINES | Per-line active bit |
| line_lvl | input | NUM_LINES | Per-line live input level |
| line_edge | input | NUM_LINES | Per-line trigger mode, 1 = edge |
| line_grp | input | NUM_LINES | Per-line group bit |
| line_prio | input | NUM_LINES*8 | Per-line priority, line i at bits [i*8 +: 8] |
| line_tgt | input | NUM_LINES*NUM_CPUS | Per-line CPU target mask, line i at [i*NUM_CPUS +: NUM_CPUS] |
| prio_mask | input | 8 | CPU priority mask |
| run_prio | input | 9 | CPU running priority, 0x100 = idle |
| dist_grp_en | input | 2 | Distributor group enables, bit g for group g |
| cpu_grp_en | input | 2 | CPU-interface group enables, bit g for group g |
| sel_id | output | 10 | Selected interrupt ID, 1023 = none |
| sel_prio | output | 9 | Priority of the selected line, 0x100 = none |
| irq_req | output | 1 | Registered interrupt request to the CPU |

## Verification
The bench targets priority ties, where a tree that prefers the right-hand operand would report the higher ID. It covers level-high lines set to edge mode, which a design that ignores the trigger bit would wrongly select. It probes the target check on both sides of ID 32, so that a private line with an empty target mask still wins and a shared line without this CPU's bit stays unselected. It sets the mask and running priority exactly equal to the winner's priority, which exposes a less-or-equal comparison. It also splits the two group enable levels apart, so that a design checking only one of them would raise a request it should hold back.

// File: rtl/prisel_pkg.sv
`timescale 1ns/1ps
package prisel_pkg;
  localparam int unsigned PRIO_W     = 8;
  localparam int unsigned ID_W       = 10;
  localparam int unsigned PRIV_LINES = 32;
  localparam logic [ID_W-1:0]  NO_ID   = 10'd1023;
  localparam logic [PRIO_W:0]  NO_PRIO = 9'h100;

  typedef struct packed {
    logic [PRIO_W:0] prio;
    logic [ID_W-1:0] id;
    logic            grp;
  } cand_t;
endpackage

// File: rtl/prisel_rst_sync.sv
`timescale 1ns/1ps
module prisel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/prisel_qualify.sv
`timescale 1ns/1ps
module prisel_qualify
  import prisel_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_CPUS  = 8,
  parameter int unsigned CPU_IDX   = 0
) (
  input  logic [NUM_LINES-1:0]          en_i,
  input  logic [NUM_LINES-1:0]          pend_i,
  input  logic [NUM_LINES-1:0]          act_i,
  input  logic [NUM_LINES-1:0]          lvl_i,
  input  logic [NUM_LINES-1:0]          edge_i,
  input  logic [NUM_LINES-1:0]          grp_i,
  input  logic [NUM_LINES*PRIO_W-1:0]   prio_i,
  input  logic [NUM_LINES*NUM_CPUS-1:0] tgt_i,
  output cand_t [NUM_LINES-1:0]         leaf_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic pend_eff, tgt_hit, eligible;

    // level-mode lines are pending while the input is high
    assign pend_eff = pend_i[i] | (lvl_i[i] & ~edge_i[i]);

    if (i < PRIV_LINES) begin : g_priv
      assign tgt_hit = 1'b1;
    end else begin : g_shared
      assign tgt_hit = tgt_i[i*NUM_CPUS + CPU_IDX];
    end

    assign eligible = en_i[i] & pend_eff & ~act_i[i] & tgt_hit;

    assign leaf_o[i] = eligible ?
      cand_t'{prio: {1'b0, prio_i[i*PRIO_W +: PRIO_W]}, id: ID_W'(i), grp: grp_i[i]} :
      cand_t'{prio: NO_PRIO, id: NO_ID, grp: 1'b0};
  end
endmodule

// File: rtl/prisel_tree.sv
`timescale 1ns/1ps
module prisel_tree
  import prisel_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64
) (
  input  cand_t [NUM_LINES-1:0] leaf_i,
  output cand_t                 best_o
);
  localparam int unsigned LVLS = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int unsigned PAD  = 1 << LVLS;

  for (genvar l = 0; l <= LVLS; l++) begin : g_lv
    cand_t nd [PAD >> l];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < PAD; j++) begin : g_j
        if (j < NUM_LINES) begin : g_real
          assign nd[j] = leaf_i[j];
        end else begin : g_pad
          assign nd[j] = cand_t'{prio: NO_PRIO, id: NO_ID, grp: 1'b0};
        end
      end
    end else begin : g_cmp
      for (genvar j = 0; j < (PAD >> l); j++) begin : g_j
        // the lower-ID operand is kept unless the other is strictly better
        assign nd[j] = (g_lv[l-1].nd[2*j+1].prio < g_lv[l-1].nd[2*j].prio) ?
                       g_lv[l-1].nd[2*j+1] : g_lv[l-1].nd[2*j];
      end
    end
  end

  assign best_o = g_lv[LVLS].nd[0];

  always_comb begin
    for (int j = 0; j < NUM_LINES; j++) begin
      a_r3_root_min: assert (!(leaf_i[j].prio < best_o.prio))
        else $error("tree root is not the minimum priority");
      a_r3_tie_low_id: assert (!((leaf_i[j].prio == best_o.prio) &&
                                 (leaf_i[j].prio != NO_PRIO) &&
                                 (leaf_i[j].id < best_o.id)))
        else $error("tie not resolved to lower ID");
    end
  end
endmodule

// File: rtl/prio_select.sv
`timescale 1ns/1ps
module prio_select
  import prisel_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_CPUS  = 8,
  parameter int unsigned CPU_IDX   = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LINES-1:0]          line_en,
  input  logic [NUM_LINES-1:0]          line_pend,
  input  logic [NUM_LINES-1:0]          line_act,
  input  logic [NUM_LINES-1:0]          line_lvl,
  input  logic [NUM_LINES-1:0]          line_edge,
  input  logic [NUM_LINES-1:0]          line_grp,
  input  logic [NUM_LINES*PRIO_W-1:0]   line_prio,
  input  logic [NUM_LINES*NUM_CPUS-1:0] line_tgt,
  input  logic [PRIO_W-1:0]             prio_mask,
  input  logic [PRIO_W:0]               run_prio,
  input  logic [1:0]                    dist_grp_en,
  input  logic [1:0]                    cpu_grp_en,
  output logic [ID_W-1:0]               sel_id,
  output logic [PRIO_W:0]               sel_prio,
  output logic                          irq_req
);
  logic                  rst_n_s;
  cand_t [NUM_LINES-1:0] leaves;
  cand_t                 best;
  logic                  pass_mask, pass_run, grp_ok;
  logic [ID_W-1:0]       id_d;
  logic [PRIO_W:0]       prio_d;
  logic                  req_d;

  prisel_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  prisel_qualify #(
    .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .CPU_IDX(CPU_IDX)
  ) u_qualify (
    .en_i(line_en), .pend_i(line_pend), .act_i(line_act), .lvl_i(line_lvl),
    .edge_i(line_edge), .grp_i(line_grp), .prio_i(line_prio), .tgt_i(line_tgt),
    .leaf_o(leaves)
  );

  prisel_tree #(.NUM_LINES(NUM_LINES)) u_tree (
    .leaf_i(leaves), .best_o(best)
  );

  // next-state
  always_comb begin
    pass_mask = best.prio < {1'b0, prio_mask};
    pass_run  = best.prio < run_prio;
    grp_ok    = dist_grp_en[best.grp] & cpu_grp_en[best.grp];
    id_d      = pass_mask ? best.id   : NO_ID;
    prio_d    = pass_mask ? best.prio : NO_PRIO;
    req_d     = pass_mask & pass_run & grp_ok;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sel_id   <= NO_ID;
      sel_prio <= NO_PRIO;
      irq_req  <= 1'b0;
    end else begin
      sel_id   <= id_d;
      sel_prio <= prio_d;
      irq_req  <= req_d;
    end
  end

  a_r1_empty_pair: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sel_id == NO_ID) |-> (sel_prio == NO_PRIO))
    else $error("empty ID with non-empty priority");

  a_r6_below_mask: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sel_id != NO_ID) |-> (sel_prio < {1'b0, $past(prio_mask)}))
    else $error("shown priority not below mask");

  a_r6_req_has_id: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req |-> (sel_id != NO_ID))
    else $error("request without a shown line");

  a_r7_run_gate: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req |-> (sel_prio < $past(run_prio)))
    else $error("request without running-priority margin");
endmodule

// File: tb/prio_select_bench.sv
`timescale 1ns/1ps
module prio_select_bench;
  import prisel_pkg::*;
  localparam int N   = 64;
  localparam int NC  = 8;
  localparam int CPU = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic [N-1:0]      en, pend, act, lvl, edg, grp;
  logic [N*8-1:0]    prio;
  logic [N*NC-1:0]   tgt;
  logic [7:0]        mask;
  logic [8:0]        run;
  logic [1:0]        dge, cge;
  logic [9:0]        sel_id;
  logic [8:0]        sel_prio;
  logic              irq_req;

  int checks = 0;
  int fails  = 0;

  prio_select #(.NUM_LINES(N), .NUM_CPUS(NC), .CPU_IDX(CPU)) u_prio_select (
    .clk(clk), .rst_n(rst_n),
    .line_en(en), .line_pend(pend), .line_act(act), .line_lvl(lvl),
    .line_edge(edg), .line_grp(grp), .line_prio(prio), .line_tgt(tgt),
    .prio_mask(mask), .run_prio(run), .dist_grp_en(dge), .cpu_grp_en(cge),
    .sel_id(sel_id), .sel_prio(sel_prio), .irq_req(irq_req)
  );

  function automatic void calc(output logic [9:0] eid, output logic [8:0] ep,
                               output logic er);
    logic [8:0] bp = 9'h100;
    logic [9:0] bi = 10'd1023;
    logic       bg = 1'b0;
    for (int i = 0; i < N; i++) begin
      logic pe, cand;
      pe   = pend[i] || (lvl[i] && !edg[i]);
      cand = en[i] && pe && !act[i] && (i < 32 || tgt[i*NC+CPU]);
      if (cand && ({1'b0, prio[i*8 +: 8]} < bp)) begin
        bp = {1'b0, prio[i*8 +: 8]};
        bi = i[9:0];
        bg = grp[i];
      end
    end
    if (bp < {1'b0, mask}) begin eid = bi; ep = bp; end
    else begin eid = 10'd1023; ep = 9'h100; end
    er = (bp < {1'b0, mask}) && (bp < run) && dge[bg] && cge[bg];
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic expect_out(string req, logic [9:0] id, logic [8:0] p, logic r);
    chk(req, "sel_id", 32'(sel_id), 32'(id));
    chk(req, "sel_prio", 32'(sel_prio), 32'(p));
    chk(req, "irq_req", 32'(irq_req), 32'(r));
  endtask

  task automatic expect_model(string req);
    logic [9:0] eid; logic [8:0] ep; logic er;
    calc(eid, ep, er);
    expect_out(req, eid, ep, er);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    en = '0; pend = '0; act = '0; lvl = '0; edg = '0; grp = '0;
    prio = '1; tgt = '0;
    mask = 8'hff; run = 9'h100; dge = 2'b11; cge = 2'b11;
  endtask

  task automatic put(int idx, logic [7:0] p, logic g, logic [7:0] t);
    en[idx] = 1'b1; pend[idx] = 1'b1; grp[idx] = g;
    prio[idx*8 +: 8] = p; tgt[idx*NC +: NC] = t;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    clear_all();
    put(7, 8'h10, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    expect_out("R1", 10'd1023, 9'h100, 1'b0);   // R1: reset state
    rst_n = 1'b1;
    repeat (4) step();

    // R2: active and disabled lines are skipped
    clear_all(); put(40, 8'h10, 1'b0, 8'(1 << CPU)); act[40] = 1'b1; step();
    expect_out("R2", 10'd1023, 9'h100, 1'b0);
    act[40] = 1'b0; step();
    expect_out("R2", 10'd40, 9'h010, 1'b1);
    en[40] = 1'b0; step();
    expect_out("R2", 10'd1023, 9'h100, 1'b0);

    // R4: level-pending versus edge mode
    clear_all(); en[12] = 1'b1; lvl[12] = 1'b1; prio[12*8 +: 8] = 8'h30; step();
    expect_out("R4", 10'd12, 9'h030, 1'b1);
    edg[12] = 1'b1; step();
    expect_out("R4", 10'd1023, 9'h100, 1'b0);

    // R3: tie goes to lower ID, strictly lower priority wins
    clear_all(); put(9, 8'h20, 1'b0, 8'h00); put(5, 8'h20, 1'b0, 8'h00); step();
    expect_out("R3", 10'd5, 9'h020, 1'b1);
    prio[9*8 +: 8] = 8'h18; step();
    expect_out("R3", 10'd9, 9'h018, 1'b1);
    clear_all(); put(63, 8'h00, 1'b0, 8'hff); put(33, 8'h00, 1'b0, 8'hff); step();
    expect_out("R3", 10'd33, 9'h000, 1'b1);

    // R5: target check only above ID 31
    clear_all(); put(3, 8'h50, 1'b0, 8'h00); step();
    expect_out("R5", 10'd3, 9'h050, 1'b1);
    clear_all(); put(50, 8'h50, 1'b0, 8'h00); step();
    expect_out("R5", 10'd1023, 9'h100, 1'b0);
    tgt[50*NC +: NC] = ~8'(1 << CPU); step();
    expect_out("R5", 10'd1023, 9'h100, 1'b0);
    tgt[50*NC +: NC] = 8'(1 << CPU); step();
    expect_out("R5", 10'd50, 9'h050, 1'b1);

    // R6: priority mask boundary
    mask = 8'h50; step();
    expect_out("R6", 10'd1023, 9'h100, 1'b0);
    mask = 8'h51; step();
    expect_out("R6", 10'd50, 9'h050, 1'b1);

    // R7: running priority boundary
    mask = 8'hff; run = 9'h050; step();
    expect_out("R7", 10'd50, 9'h050, 1'b0);
    run = 9'h051; step();
    expect_out("R7", 10'd50, 9'h050, 1'b1);

    // R8: two-level group enables
    run = 9'h100; grp[50] = 1'b1; dge = 2'b01; cge = 2'b11; step();
    expect_out("R8", 10'd50, 9'h050, 1'b0);
    dge = 2'b11; cge = 2'b01; step();
    expect_out("R8", 10'd50, 9'h050, 1'b0);
    dge = 2'b10; cge = 2'b10; step();
    expect_out("R8", 10'd50, 9'h050, 1'b1);
    grp[50] = 1'b0; step();
    expect_out("R8", 10'd50, 9'h050, 1'b0);

    // R9: outputs hold until the next rising edge
    dge = 2'b11; cge = 2'b11; step();
    prio[50*8 +: 8] = 8'h20; #1;
    expect_out("R9", 10'd50, 9'h050, 1'b1);
    step();
    expect_out("R9", 10'd50, 9'h020, 1'b1);

    // random mix
    for (int it = 0; it < 1500; it++) begin
      en   = {$urandom, $urandom};
      pend = {$urandom, $urandom} & {$urandom, $urandom};
      act  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      lvl  = {$urandom, $urandom};
      edg  = {$urandom, $urandom};
      grp  = {$urandom, $urandom};
      for (int i = 0; i < N; i++) begin
        prio[i*8 +: 8] = 8'(($urandom % 6) * 40);
        tgt[i*NC +: NC] = 8'($urandom);
      end
      mask = ($urandom % 2) ? 8'hff : 8'($urandom);
      run  = ($urandom % 2) ? 9'h100 : 9'($urandom % 257);
      dge  = 2'($urandom);
      cge  = 2'($urandom);
      step();
      expect_model("R2/R3/R4/R5/R6/R7/R8");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule